// File: doc/BRIEF.md
# Integer Square Root Peripheral

This block is a memory-mapped accelerator that a processor reaches over an AXI4-Lite slave port. Software places a 32-bit unsigned operand in one register and launches the computation by writing a command bit to a second register. It then polls a status word for busy, finished and error flags, and reads the floor square root from a fourth register once the finished flag is set.

Two registers accept writes and two are read-only views of the compute engine. The engine is iterative and serial. It uses a non-restoring radix-2 recurrence that settles one root bit per clock, so a 32-bit operand gives a 16-bit root after 16 steps. The root is zero-extended to the bus width. An operand whose top bit is set is refused: the error flag rises and the result reads zero, so that a value a caller meant as a negative number is not treated as a large positive one. Clock and active-low reset are the AXI4-Lite clock and reset.

Top module: `sqrt_mmio_periph`

## Requirements
- R1: After reset all four registers read zero and no write response or read data is pending.
- R2: Byte offset 0x0 (operand) and byte offset 0x4 (control) are read/write, and write strobe bit k updates only byte k (bits 8k+7:8k) of the addressed register.
- R3: Byte offset 0x8 reads the status word with bit 0 = end (result valid), bit 1 = run (busy), bit 2 = error and bits 31:3 zero. Byte offset 0xC reads the result with the root in bits 15:0 and bits 31:16 zero.
- R4: Writes to offsets 0x8 and 0xC change neither the status nor the result.
- R5: A write to offset 0x4 with strobe bit 0 set and data bit 0 set launches a computation: a status read issued after the write response returns run = 1, end = 0 and error = 0.
- R6: End sets and run clears 17 clock edges after the launching write handshake (one edge for the command pulse and 16 engine steps), and end then stays set until the next launch.
- R7: For an operand with bit 31 clear, the result is the largest r with r*r no greater than the operand.
- R8: For an operand with bit 31 set, the computation ends with error = 1 and a result of zero.
- R9: A launch command while run is high is ignored: the computation in flight keeps the operand it captured at launch, even if the operand register is rewritten.
- R10: Every write and read response is OKAY (code 2'b00), and a pending response stays valid with stable data until it is accepted.
- R11: A control write with data bit 0 clear, or with strobe bit 0 clear, does not launch a computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock, also clocks the engine |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted by master |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted by master |

## Verification
The bench builds the block with its defaults, a 32-bit data path and a 4-bit byte address, so the engine runs its full 16 steps and the latency check sees the exact step count. This width makes the error boundary at bit 31 and the largest legal operand 0x7FFFFFFF (root 46340) reachable as plain bus writes. It also allows an overlapping launch to be placed well inside one computation, and single-lane strobe patterns to be checked against a four-byte register.

// File: rtl/sqrt_mmio_pkg.sv
package sqrt_mmio_pkg;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

    // Register slots, selected by the word index of the byte address
    localparam logic [1:0] SLOT_OPERAND = 2'd0;
    localparam logic [1:0] SLOT_CONTROL = 2'd1;
    localparam logic [1:0] SLOT_STATUS  = 2'd2;
    localparam logic [1:0] SLOT_RESULT  = 2'd3;

    // Status word bit positions
    localparam int FLAG_END = 0;
    localparam int FLAG_RUN = 1;
    localparam int FLAG_ERR = 2;

    // Control word bit position
    localparam int CMD_GO = 0;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/sqrt_axil_regs.sv
module sqrt_axil_regs
    import sqrt_mmio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    // engine side
    output logic [DATA_W-1:0]   operand,
    output logic                start,
    input  logic                eng_run,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic [DATA_W-1:0]   eng_result
);

    localparam int STRB_W   = DATA_W / 8;
    localparam int SLOT_LSB = $clog2(STRB_W);

    typedef struct packed {
        logic [DATA_W-1:0] operand;
        logic [DATA_W-1:0] control;
        logic [DATA_W-1:0] rdata;
        logic              start;
        logic              bvalid;
        logic              rvalid;
    } regs_t;

    regs_t q, d;

    logic              wr_go;
    logic              rd_go;
    logic [1:0]        wr_slot;
    logic [1:0]        rd_slot;
    logic [DATA_W-1:0] status_word;
    logic              unused_addr_bits;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] lanes
    );
        logic [DATA_W-1:0] merged;
        merged = old_v;
        for (int i = 0; i < STRB_W; i++) begin
            if (lanes[i]) merged[i*8 +: 8] = new_v[i*8 +: 8];
        end
        return merged;
    endfunction

    assign wr_slot = awaddr[SLOT_LSB +: 2];
    assign rd_slot = araddr[SLOT_LSB +: 2];
    assign unused_addr_bits = ^{awaddr, araddr};

    // Address and data are taken together, one write at a time
    assign wr_go   = awvalid && wvalid && !q.bvalid;
    assign rd_go   = arvalid && !q.rvalid;

    always_comb begin
        status_word           = '0;
        status_word[FLAG_END] = eng_done;
        status_word[FLAG_RUN] = eng_run;
        status_word[FLAG_ERR] = eng_err;
    end

    always_comb begin
        d       = q;
        d.start = 1'b0;

        if (q.bvalid && bready) d.bvalid = 1'b0;
        if (wr_go) begin
            d.bvalid = 1'b1;
            unique case (wr_slot)
                SLOT_OPERAND: d.operand = lane_merge(q.operand, wdata, wstrb);
                SLOT_CONTROL: begin
                    d.control = lane_merge(q.control, wdata, wstrb);
                    d.start   = wstrb[CMD_GO / 8] && wdata[CMD_GO];
                end
                default: ;   // status and result are not writable
            endcase
        end

        if (q.rvalid && rready) d.rvalid = 1'b0;
        if (rd_go) begin
            d.rvalid = 1'b1;
            unique case (rd_slot)
                SLOT_OPERAND: d.rdata = q.operand;
                SLOT_CONTROL: d.rdata = q.control;
                SLOT_STATUS:  d.rdata = status_word;
                SLOT_RESULT:  d.rdata = eng_result;
                default:      d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign awready = wr_go;
    assign wready  = wr_go;
    assign bvalid  = q.bvalid;
    assign bresp   = RESP_OKAY;
    assign arready = !q.rvalid;
    assign rvalid  = q.rvalid;
    assign rdata   = q.rdata;
    assign rresp   = RESP_OKAY;
    assign operand = q.operand;
    assign start   = q.start;

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid); // R10
    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata)); // R10
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R5
    AST_WRITE_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready); // R10

endmodule

// File: rtl/sqrt_engine.sv
module sqrt_engine
    import sqrt_mmio_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              run,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] result
);

    localparam int ROOT_W = DATA_W / 2;
    localparam int REM_W  = ROOT_W + 4;
    localparam int CNT_W  = $clog2(ROOT_W + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(ROOT_W);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] src;    // operand captured at launch
        logic [DATA_W-1:0] opnd;   // digit pairs still to consume, top first
        logic [REM_W-1:0]  rem;    // two's complement partial remainder
        logic [ROOT_W-1:0] root;
        logic              done;
        logic              err;
    } eng_t;

    eng_t q, d;

    logic [REM_W-1:0]  trial;
    logic [REM_W-1:0]  rem_nx;
    logic [ROOT_W-1:0] root_nx;

    // One non-restoring step: bring down a digit pair, then subtract
    // (root<<2 | 1) on a non-negative remainder or add (root<<2 | 3) on a
    // negative one; the sign of the new remainder is the next root bit.
    always_comb begin
        trial = {q.rem[REM_W-3:0], q.opnd[DATA_W-1 -: 2]};
        if (!q.rem[REM_W-1]) rem_nx = trial - {2'b00, q.root, 2'b01};
        else                 rem_nx = trial + {2'b00, q.root, 2'b11};
        root_nx = {q.root[ROOT_W-2:0], ~rem_nx[REM_W-1]};
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ENG_IDLE: begin
                if (start) begin
                    d.st   = ENG_BUSY;
                    d.cnt  = STEPS;
                    d.src  = operand;
                    d.opnd = operand;
                    d.rem  = '0;
                    d.root = '0;
                    d.done = 1'b0;
                    d.err  = 1'b0;
                end
            end
            ENG_BUSY: begin
                d.rem  = rem_nx;
                d.root = root_nx;
                d.opnd = q.opnd << 2;
                d.cnt  = q.cnt - 1'b1;
                if (q.cnt == CNT_W'(1)) begin
                    d.st   = ENG_IDLE;
                    d.done = 1'b1;
                    d.err  = q.src[DATA_W-1];
                    if (q.src[DATA_W-1]) d.root = '0;
                end
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run    = (q.st == ENG_BUSY);
    assign done   = q.done;
    assign err    = q.err;
    assign result = {{(DATA_W-ROOT_W){1'b0}}, q.root};

    // Wide copies used to check the floor-root property on completion
    logic [2*DATA_W-1:0] root_ext;
    logic [2*DATA_W-1:0] src_ext;
    logic [2*DATA_W-1:0] sq_lo;
    logic [2*DATA_W-1:0] sq_hi;
    assign root_ext = {{(2*DATA_W-ROOT_W){1'b0}}, q.root};
    assign src_ext  = {{DATA_W{1'b0}}, q.src};
    assign sq_lo    = root_ext * root_ext;
    assign sq_hi    = (root_ext + 1'b1) * (root_ext + 1'b1);

    AST_RUN_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && done)); // R6
    AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R6
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !run && start |=> run && !done && !err); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        run && start |=> $stable(q.src)); // R9
    AST_FLOOR_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> (sq_lo <= src_ext) && (sq_hi > src_ext)); // R7
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == q.src[DATA_W-1])); // R8
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (result == '0)); // R8

endmodule

// File: rtl/sqrt_mmio_periph.sv
module sqrt_mmio_periph
    import sqrt_mmio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                aclk,
    input  logic                aresetn,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready
);

    logic [DATA_W-1:0] operand;
    logic              start;
    logic              eng_run;
    logic              eng_done;
    logic              eng_err;
    logic [DATA_W-1:0] eng_result;

    sqrt_axil_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (aclk),
        .rst_n      (aresetn),
        .awaddr     (s_awaddr),
        .awvalid    (s_awvalid),
        .awready    (s_awready),
        .wdata      (s_wdata),
        .wstrb      (s_wstrb),
        .wvalid     (s_wvalid),
        .wready     (s_wready),
        .bresp      (s_bresp),
        .bvalid     (s_bvalid),
        .bready     (s_bready),
        .araddr     (s_araddr),
        .arvalid    (s_arvalid),
        .arready    (s_arready),
        .rdata      (s_rdata),
        .rresp      (s_rresp),
        .rvalid     (s_rvalid),
        .rready     (s_rready),
        .operand    (operand),
        .start      (start),
        .eng_run    (eng_run),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .eng_result (eng_result)
    );

    sqrt_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk     (aclk),
        .rst_n   (aresetn),
        .start   (start),
        .operand (operand),
        .run     (eng_run),
        .done    (eng_done),
        .err     (eng_err),
        .result  (eng_result)
    );

endmodule

// File: tb/tb_sqrt_mmio_periph.sv
`timescale 1ns/1ps
module tb_sqrt_mmio_periph;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int ROOT_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] OFF_OPERAND = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_CONTROL = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_RESULT  = 4'hC;
    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic aresetn = 1'b0;
    always #2.5 clk = ~clk;

    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
    logic [DATA_W-1:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DATA_W-1:0] rdata;

    sqrt_mmio_periph dut (
        .aclk(clk), .aresetn(aresetn),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int wr_cyc = 0;
    int rd_cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard queues: one entry per issued read; mask 0 means poll only
    logic [31:0] exp_q[$];
    logic [31:0] mask_q[$];
    string       tag_q[$];

    task automatic tally(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data and response codes as they appear
    always @(negedge clk) begin
        logic [31:0] e, m;
        string t;
        if (rvalid && rready) begin
            if (exp_q.size() == 0) begin
                tally(1'b0, "R10 read data without request", rdata, 32'h0);
            end else begin
                e = exp_q.pop_front();
                m = mask_q.pop_front();
                t = tag_q.pop_front();
                if (m != 32'h0) begin
                    tally((rdata & m) == (e & m), t, rdata & m, e & m);
                    tally(rresp == 2'b00, "R10 read response OKAY", {30'h0, rresp}, 32'h0);
                end
            end
        end
        if (bvalid && bready)
            tally(bresp == 2'b00, "R10 write response OKAY", {30'h0, bresp}, 32'h0);
    end

    task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [31:0] dv, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = dv; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!awready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic axi_read(input logic [ADDR_W-1:0] a, output logic [31:0] dv,
                            input logic [31:0] e, input logic [31:0] m, input string t);
        exp_q.push_back(e);
        mask_q.push_back(m);
        tag_q.push_back(t);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        dv = rdata;
        rd_cyc = cyc;
    endtask

    task automatic check_read(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                              input logic [31:0] m, input string t);
        logic [31:0] dummy;
        axi_read(a, dummy, e, m, t);
    endtask

    task automatic wait_end();
        logic [31:0] st;
        st = '0;
        while (!st[0]) axi_read(OFF_STATUS, st, 32'h0, 32'h0, "");
    endtask

    function automatic logic [31:0] ref_root(input logic [31:0] v);
        logic [31:0] r, c;
        r = '0;
        for (int b = ROOT_W - 1; b >= 0; b--) begin
            c = r | (32'h1 << b);
            if (64'(c) * 64'(c) <= 64'(v)) r = c;
        end
        return r;
    endfunction

    // Driver: one full software sequence for one operand
    task automatic run_case(input logic [31:0] v);
        int el;
        axi_write(OFF_OPERAND, v, 4'hF);
        axi_write(OFF_CONTROL, 32'h1, 4'hF);
        el = wr_cyc;
        check_read(OFF_STATUS, 32'h2, ALL, "R5 status just after launch");
        wait_end();
        el = rd_cyc - el;
        tally(el >= ROOT_W + 2 && el <= ROOT_W + 3, "R6 launch-to-end latency", el, ROOT_W + 2);
        if (v[31]) begin
            check_read(OFF_STATUS, 32'h5, ALL, "R8 final status end+error");
            check_read(OFF_RESULT, 32'h0, ALL, "R8 result forced to zero");
        end else begin
            check_read(OFF_STATUS, 32'h1, ALL, "R3 final status end only");
            check_read(OFF_RESULT, ref_root(v), ALL, "R7 floor root");
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        tally(!bvalid, "R1 no write response in reset", {31'h0, bvalid}, 32'h0);
        tally(!rvalid, "R1 no read data in reset", {31'h0, rvalid}, 32'h0);
        aresetn = 1'b1;
        repeat (2) @(negedge clk);

        // R1 all registers zero
        check_read(OFF_OPERAND, 32'h0, ALL, "R1 operand after reset");
        check_read(OFF_CONTROL, 32'h0, ALL, "R1 control after reset");
        check_read(OFF_STATUS,  32'h0, ALL, "R1 status after reset");
        check_read(OFF_RESULT,  32'h0, ALL, "R1 result after reset");

        // R2 read/write registers and byte strobes
        axi_write(OFF_OPERAND, 32'hAABB_CCDD, 4'hF);
        check_read(OFF_OPERAND, 32'hAABB_CCDD, ALL, "R2 operand full write");
        axi_write(OFF_OPERAND, 32'h1122_3344, 4'b0101);
        check_read(OFF_OPERAND, 32'hAA22_CC44, ALL, "R2 operand lanes 0 and 2");

        // R11 control writes that must not launch
        axi_write(OFF_CONTROL, 32'hFFFF_FFF0, 4'hF);
        check_read(OFF_CONTROL, 32'hFFFF_FFF0, ALL, "R2 control readback");
        check_read(OFF_STATUS, 32'h0, ALL, "R11 go bit clear gives no launch");
        axi_write(OFF_CONTROL, 32'h0000_0101, 4'b1110);
        check_read(OFF_CONTROL, 32'h0000_01F0, ALL, "R2 control lanes 1 to 3");
        check_read(OFF_STATUS, 32'h0, ALL, "R11 lane 0 disabled gives no launch");

        // R4 writes to read-only slots
        axi_write(OFF_STATUS, ALL, 4'hF);
        axi_write(OFF_RESULT, ALL, 4'hF);
        check_read(OFF_STATUS, 32'h0, ALL, "R4 status write ignored");
        check_read(OFF_RESULT, 32'h0, ALL, "R4 result write ignored");

        // Main function across boundaries
        run_case(32'd0);
        run_case(32'd1);
        run_case(32'd2);
        run_case(32'd3);
        run_case(32'd4);
        run_case(32'd15);
        run_case(32'd16);
        run_case(32'd17);
        run_case(32'h8000_0000);   // error, then a clean run clears it
        run_case(32'd1_000_000);
        run_case(32'h7FFF_FFFF);
        run_case(32'h3FFF_FFFF);
        run_case(32'hFFFF_FFFF);
        run_case(32'h1234_5678);
        for (int i = 0; i < 6; i++) run_case($urandom & 32'h7FFF_FFFF);
        run_case(32'd99);

        // R4 after a result exists; R6 end persists
        axi_write(OFF_RESULT, 32'h0, 4'hF);
        check_read(OFF_RESULT, 32'd9, ALL, "R4 result survives write");
        axi_write(OFF_STATUS, ALL, 4'hF);
        repeat (30) @(negedge clk);
        check_read(OFF_STATUS, 32'h1, ALL, "R6 end held while idle");
        axi_write(OFF_OPERAND, 32'd12345, 4'hF);
        check_read(OFF_STATUS, 32'h1, ALL, "R6 end held after operand write");
        check_read(OFF_RESULT, 32'd9, ALL, "R6 result held after operand write");

        // R9 launch while busy is ignored
        axi_write(OFF_OPERAND, 32'd1_000_000, 4'hF);
        axi_write(OFF_CONTROL, 32'h1, 4'hF);
        axi_write(OFF_OPERAND, 32'h7FFF_FFFF, 4'hF);
        axi_write(OFF_CONTROL, 32'h1, 4'hF);
        check_read(OFF_STATUS, 32'h2, ALL, "R9 still running after second launch");
        wait_end();
        check_read(OFF_RESULT, 32'd1000, ALL, "R9 result of captured operand");
        check_read(OFF_OPERAND, 32'h7FFF_FFFF, ALL, "R2 operand rewritten during run");
        repeat (30) @(negedge clk);
        check_read(OFF_STATUS, 32'h1, ALL, "R9 no deferred second run");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule